// File: doc/BRIEF.md
# Privileged Address Window Decoder

This block looks at every 32-bit address the CPU issues and decides which architectural region it belongs to. For each address it works out the physical address, whether the access may be cached, whether the access is illegal, and whether a later translation stage must look the address up. The results appear on registered outputs one clock after the address is presented.

The user-space region and the upper translatable region are only tagged for translation. When translation is off they pass through unchanged. The two direct windows are never translated. The legacy mode select picks between two ways of mapping those windows:

- In legacy mode each window is a fixed alias of the low 512 MB.
- In extended mode each window is remapped through a table of eight mapping entries, which software writes through a simple write port. Each entry supplies the physical base and the cacheable attribute.

The top control region is an alias of the control-register area. Privileged code reaches all of it. User code reaches only two parameterised sub-ranges.

Top module: `awd_decoder`

## Requirements
- R1: Each address is classified by its top bits into a region code on `out_region`: 0 user space (0x00000000–0x7FFFFFFF), 1 cached window (0x80000000–0x9FFFFFFF), 2 uncached window (0xA0000000–0xBFFFFFFF), 3 upper translatable (0xC0000000–0xDFFFFFFF), 4 reserved (0xE0000000–0xFBFFFFFF), 5 control region (0xFC000000–0xFFFFFFFF).
- R2: All outputs are registered. They reflect the inputs of the previous clock edge. During reset all outputs are zero.
- R3: A user-space address never faults in either privilege mode. It gives `out_paddr` equal to the address and `out_cacheable` 1, and `out_need_xlat` equals `xlat_en`.
- R4: In legacy mode (`ext_mode`=0), a privileged window access maps to the address with its top three bits cleared, and the mapping table is ignored. The cached window gives `out_cacheable`=1 and the uncached window gives 0.
- R5: A window access (region 1 or 2) never asserts `out_need_xlat`, even with `xlat_en`=1.
- R6: In extended mode, a privileged window access uses the lowest-numbered valid entry whose window select matches (0 = cached window, 1 = uncached window). The physical address is the entry's 3-bit base on bits 31:29, followed by address bits 28:0, and `out_cacheable` is the entry's cacheable bit.
- R7: In extended mode, a window access that matches no valid entry faults.
- R8: A privileged access to the upper translatable region gives `out_paddr` equal to the address and `out_cacheable`=1, and `out_need_xlat` equals `xlat_en`.
- R9: A user-mode (`in_priv`=0) access to region 1, 2 or 3 faults.
- R10: Any access to the reserved region faults.
- R11: A control-region access maps to the address with its top three bits cleared (0x1C000000–0x1FFFFFFF), is non-cacheable, and does not fault in privileged mode.
- R12: A user-mode control-region access faults unless the address lies in the RAM sub-range (default 0xFE000000–0xFE3FFFFF) or the queue sub-range (default 0xFF800000–0xFF80003F), both bounds inclusive.
- R13: Whenever `out_fault` is 1, `out_paddr` is 0 and `out_cacheable` and `out_need_xlat` are 0.
- R14: A write on `map_we` stores {`map_valid`, `map_win`, `map_base`, `map_cache`} in entry `map_idx`. The new entry affects addresses presented from the next cycle on. Reset clears every entry to invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_addr | input | 32 | CPU address to decode |
| in_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| xlat_en | input | 1 | Address translation enabled |
| ext_mode | input | 1 | 1 = window mapping through the table, 0 = legacy fixed alias |
| map_we | input | 1 | Mapping entry write strobe |
| map_idx | input | 3 | Entry number to write |
| map_valid | input | 1 | Valid bit written to the entry |
| map_win | input | 1 | Window select written (0 cached, 1 uncached) |
| map_base | input | 3 | Physical 512 MB base written |
| map_cache | input | 1 | Cacheable bit written |
| out_region | output | 3 | Region code of the previous address |
| out_paddr | output | 32 | Physical address |
| out_cacheable | output | 1 | Access may be cached |
| out_fault | output | 1 | Access is not allowed |
| out_need_xlat | output | 1 | Address must go through translation |

## Verification
Every cycle, the assertions check the following:
- the fault encoding (zero address, no cache, no translation);
- the absence of translation requests for the windows;
- user faults on the privileged regions and faults on the reserved range;
- the legacy window alias, upper-region pass-through and privileged control-region alias, each one cycle after its input.

Only the bench scenarios can show the following:
- the extended-mode table behaviour, including lowest-index priority, miss faults, the one-cycle delay between a table write and its effect, and reset clearing the table;
- the exact edges of the user sub-ranges in the control region.

// File: rtl/awd_pkg.sv
package awd_pkg;

    localparam int ADDR_W = 32;
    localparam int BASE_W = 3;

    typedef enum logic [2:0] {
        RGN_USER  = 3'd0,
        RGN_WIN_C = 3'd1,
        RGN_WIN_U = 3'd2,
        RGN_UPPER = 3'd3,
        RGN_RSVD  = 3'd4,
        RGN_CTRL  = 3'd5
    } region_e;

    typedef struct packed {
        logic              valid;
        logic              win;
        logic [BASE_W-1:0] base;
        logic              cache;
    } map_entry_t;

endpackage

// File: rtl/awd_region_classify.sv
module awd_region_classify
    import awd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique casez (addr[TOP -: 3])
            3'b0??:  region = RGN_USER;
            3'b100:  region = RGN_WIN_C;
            3'b101:  region = RGN_WIN_U;
            3'b110:  region = RGN_UPPER;
            default: region = (addr[TOP-3 -: 3] == 3'b111) ? RGN_CTRL : RGN_RSVD;
        endcase
    end

endmodule

// File: rtl/awd_map_table.sv
module awd_map_table
    import awd_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  map_entry_t        wr_entry,
    input  logic              look_win,
    output logic              hit,
    output logic [BASE_W-1:0] hit_base,
    output logic              hit_cache
);

    map_entry_t entry_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry_q[g] <= wr_entry;
            end
        end
    end

    // Scan downward so the lowest matching index is the last one assigned.
    always_comb begin
        hit       = 1'b0;
        hit_base  = '0;
        hit_cache = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (entry_q[i].valid && (entry_q[i].win == look_win)) begin
                hit       = 1'b1;
                hit_base  = entry_q[i].base;
                hit_cache = entry_q[i].cache;
            end
        end
    end

endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
    import awd_pkg::*;
#(
    parameter int          MAP_ENTRIES = 8,
    parameter logic [31:0] USR_RAM_LO  = 32'hFE00_0000,
    parameter logic [31:0] USR_RAM_HI  = 32'hFE3F_FFFF,
    parameter logic [31:0] USR_SQ_LO   = 32'hFF80_0000,
    parameter logic [31:0] USR_SQ_HI   = 32'hFF80_003F
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] in_addr,
    input  logic        in_priv,
    input  logic        xlat_en,
    input  logic        ext_mode,
    input  logic        map_we,
    input  logic [2:0]  map_idx,
    input  logic        map_valid,
    input  logic        map_win,
    input  logic [2:0]  map_base,
    input  logic        map_cache,
    output logic [2:0]  out_region,
    output logic [31:0] out_paddr,
    output logic        out_cacheable,
    output logic        out_fault,
    output logic        out_need_xlat
);

    localparam int LOW_W = ADDR_W - BASE_W;
    localparam int IDX_W = (MAP_ENTRIES > 1) ? $clog2(MAP_ENTRIES) : 1;

    region_e           region_d;
    map_entry_t        wr_entry;
    logic              tbl_hit;
    logic [BASE_W-1:0] tbl_base;
    logic              tbl_cache;

    logic [ADDR_W-1:0] paddr_d;
    logic              cache_d;
    logic              fault_d;
    logic              xlat_d;
    logic              user_ok;

    awd_region_classify u_cls (
        .addr   (in_addr),
        .region (region_d)
    );

    assign wr_entry = '{valid: map_valid, win: map_win, base: map_base, cache: map_cache};

    awd_map_table #(.ENTRIES(MAP_ENTRIES)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (map_we),
        .wr_idx    (IDX_W'(map_idx)),
        .wr_entry  (wr_entry),
        .look_win  (region_d == RGN_WIN_U),
        .hit       (tbl_hit),
        .hit_base  (tbl_base),
        .hit_cache (tbl_cache)
    );

    assign user_ok = ((in_addr >= USR_RAM_LO) && (in_addr <= USR_RAM_HI)) ||
                     ((in_addr >= USR_SQ_LO)  && (in_addr <= USR_SQ_HI));

    always_comb begin
        paddr_d = '0;
        cache_d = 1'b0;
        fault_d = 1'b0;
        xlat_d  = 1'b0;
        unique case (region_d)
            RGN_USER: begin
                paddr_d = in_addr;
                cache_d = 1'b1;
                xlat_d  = xlat_en;
            end
            RGN_WIN_C, RGN_WIN_U: begin
                if (!in_priv) begin
                    fault_d = 1'b1;
                end else if (!ext_mode) begin
                    paddr_d = {{BASE_W{1'b0}}, in_addr[LOW_W-1:0]};
                    cache_d = (region_d == RGN_WIN_C);
                end else if (tbl_hit) begin
                    paddr_d = {tbl_base, in_addr[LOW_W-1:0]};
                    cache_d = tbl_cache;
                end else begin
                    fault_d = 1'b1;
                end
            end
            RGN_UPPER: begin
                if (!in_priv) begin
                    fault_d = 1'b1;
                end else begin
                    paddr_d = in_addr;
                    cache_d = 1'b1;
                    xlat_d  = xlat_en;
                end
            end
            RGN_CTRL: begin
                if (!in_priv && !user_ok) begin
                    fault_d = 1'b1;
                end else begin
                    paddr_d = {{BASE_W{1'b0}}, in_addr[LOW_W-1:0]};
                end
            end
            default: fault_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_region    <= '0;
            out_paddr     <= '0;
            out_cacheable <= 1'b0;
            out_fault     <= 1'b0;
            out_need_xlat <= 1'b0;
        end else begin
            out_region    <= region_d;
            out_paddr     <= paddr_d;
            out_cacheable <= cache_d;
            out_fault     <= fault_d;
            out_need_xlat <= xlat_d;
        end
    end

endmodule

// File: rtl/awd_decoder_checker.sv
module awd_decoder_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] in_addr,
    input logic        in_priv,
    input logic        xlat_en,
    input logic        ext_mode,
    input logic [2:0]  out_region,
    input logic [31:0] out_paddr,
    input logic        out_cacheable,
    input logic        out_fault,
    input logic        out_need_xlat
);

    logic pend_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
        end else begin
            pend_valid <= 1'b1;
        end
    end

    AST_WINDOW_NO_XLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_region == 3'd1 || out_region == 3'd2) |-> !out_need_xlat); // R5

    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_paddr == 32'h0 && !out_cacheable && !out_need_xlat)); // R13

    AST_USER_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !in_priv && in_addr[31] && in_addr[31:29] != 3'b111) |=> out_fault); // R9

    AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && in_addr[31:29] == 3'b111 && in_addr[28:26] != 3'b111) |=> (out_fault && out_region == 3'd4)); // R10

    AST_LEGACY_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && in_priv && !ext_mode && in_addr[31:29] == 3'b100)
        |=> (out_paddr == {3'b000, $past(in_addr[28:0])} && out_cacheable)); // R4

    AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && in_priv && in_addr[31:29] == 3'b110)
        |=> (out_paddr == $past(in_addr) && out_need_xlat == $past(xlat_en))); // R8

    AST_CTRL_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && in_priv && in_addr[31:26] == 6'h3F)
        |=> (!out_fault && !out_cacheable && out_paddr[31:26] == 6'b000111)); // R11

endmodule

bind awd_decoder awd_decoder_checker u_awd_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_addr       (in_addr),
    .in_priv       (in_priv),
    .xlat_en       (xlat_en),
    .ext_mode      (ext_mode),
    .out_region    (out_region),
    .out_paddr     (out_paddr),
    .out_cacheable (out_cacheable),
    .out_fault     (out_fault),
    .out_need_xlat (out_need_xlat)
);

// File: tb/tb_awd_decoder.sv
module tb_awd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_addr = '0;
    logic        in_priv = 1'b0;
    logic        xlat_en = 1'b0;
    logic        ext_mode = 1'b0;
    logic        map_we = 1'b0;
    logic [2:0]  map_idx = '0;
    logic        map_valid = 1'b0;
    logic        map_win = 1'b0;
    logic [2:0]  map_base = '0;
    logic        map_cache = 1'b0;
    logic [2:0]  out_region;
    logic [31:0] out_paddr;
    logic        out_cacheable;
    logic        out_fault;
    logic        out_need_xlat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    awd_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_addr(in_addr), .in_priv(in_priv),
        .xlat_en(xlat_en), .ext_mode(ext_mode), .map_we(map_we), .map_idx(map_idx),
        .map_valid(map_valid), .map_win(map_win), .map_base(map_base), .map_cache(map_cache),
        .out_region(out_region), .out_paddr(out_paddr), .out_cacheable(out_cacheable),
        .out_fault(out_fault), .out_need_xlat(out_need_xlat)
    );

    // {addr, priv, xlat, ext, region, paddr, cache, fault, need_xlat}
    localparam int NV = 17;
    localparam logic [72:0] VEC [NV] = '{
        {32'h1234_5678, 3'b000, 3'd0, 32'h1234_5678, 3'b100}, // R3 user, xlat off
        {32'h7FFF_FFFC, 3'b110, 3'd0, 32'h7FFF_FFFC, 3'b101}, // R3 xlat on
        {32'h8ABC_DEF0, 3'b100, 3'd1, 32'h0ABC_DEF0, 3'b100}, // R4 cached window
        {32'hA000_1000, 3'b110, 3'd2, 32'h0000_1000, 3'b000}, // R4 R5 uncached, xlat on
        {32'hC123_4560, 3'b100, 3'd3, 32'hC123_4560, 3'b100}, // R8 xlat off
        {32'hDFFF_FFF0, 3'b110, 3'd3, 32'hDFFF_FFF0, 3'b101}, // R8 xlat on
        {32'h8000_0000, 3'b000, 3'd1, 32'h0000_0000, 3'b010}, // R9 R13 user window
        {32'hC000_0000, 3'b010, 3'd3, 32'h0000_0000, 3'b010}, // R9 R13 user upper
        {32'hE000_0000, 3'b100, 3'd4, 32'h0000_0000, 3'b010}, // R10 low edge
        {32'hFBFF_FFFF, 3'b100, 3'd4, 32'h0000_0000, 3'b010}, // R10 high edge
        {32'hFF00_0010, 3'b100, 3'd5, 32'h1F00_0010, 3'b000}, // R11
        {32'hFC00_0000, 3'b110, 3'd5, 32'h1C00_0000, 3'b000}, // R11 low edge, R1
        {32'hFE00_0000, 3'b000, 3'd5, 32'h1E00_0000, 3'b000}, // R12 RAM low bound
        {32'hFF80_003F, 3'b000, 3'd5, 32'h1F80_003F, 3'b000}, // R12 queue high bound
        {32'hFF00_0010, 3'b000, 3'd5, 32'h0000_0000, 3'b010}, // R12 outside
        {32'hFE40_0000, 3'b000, 3'd5, 32'h0000_0000, 3'b010}, // R12 above RAM
        {32'h9000_0000, 3'b101, 3'd1, 32'h0000_0000, 3'b010}  // R7 empty table
    };

    task automatic expect_out(input string req, input logic [2:0] rg, input logic [31:0] pa,
                              input logic c, input logic f, input logic nx);
        checks++;
        if (out_region !== rg || out_paddr !== pa || out_cacheable !== c ||
            out_fault !== f || out_need_xlat !== nx) begin
            errors++;
            $display("FAIL %s: got rgn=%0d pa=%h c=%b f=%b nx=%b, want rgn=%0d pa=%h c=%b f=%b nx=%b",
                     req, out_region, out_paddr, out_cacheable, out_fault, out_need_xlat,
                     rg, pa, c, f, nx);
        end
    endtask

    task automatic present(input logic [31:0] a, input logic p, input logic x, input logic e);
        @(negedge clk);
        in_addr = a; in_priv = p; xlat_en = x; ext_mode = e;
    endtask

    task automatic wr_map(input logic [2:0] idx, input logic v, input logic w,
                          input logic [2:0] b, input logic c);
        @(negedge clk);
        map_we = 1'b1; map_idx = idx; map_valid = v; map_win = w; map_base = b; map_cache = c;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        in_addr = 32'hFFFF_FFFF; in_priv = 1'b1; xlat_en = 1'b1;
        repeat (3) @(negedge clk);
        expect_out("R2 reset", 3'd0, 32'h0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            present(VEC[i][72:41], VEC[i][40], VEC[i][39], VEC[i][38]);
            @(negedge clk);
            expect_out($sformatf("R1 table vector %0d", i), VEC[i][37:35], VEC[i][34:3],
                       VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R14 R6: idx5 cached window base 5 uncached-attr; idx2 cached window base 3 cacheable; idx0 uncached window base 7
        wr_map(3'd5, 1'b1, 1'b0, 3'd5, 1'b0);
        wr_map(3'd2, 1'b1, 1'b0, 3'd3, 1'b1);
        wr_map(3'd0, 1'b1, 1'b1, 3'd7, 1'b0);
        present(32'h8000_0040, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        expect_out("R6 lowest index wins", 3'd1, 32'h6000_0040, 1'b1, 1'b0, 1'b0);
        present(32'hA123_4567, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        expect_out("R6 uncached window entry", 3'd2, 32'hE123_4567, 1'b0, 1'b0, 1'b0);
        present(32'h8000_0040, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R4 legacy ignores table", 3'd1, 32'h0000_0040, 1'b1, 1'b0, 1'b0);

        // R14 write and lookup in the same cycle: old entry still used
        present(32'h8000_0040, 1'b1, 1'b0, 1'b1);
        map_we = 1'b1; map_idx = 3'd2; map_valid = 1'b0; map_win = 1'b0; map_base = 3'd3; map_cache = 1'b1;
        @(negedge clk);
        map_we = 1'b0;
        expect_out("R14 write not yet visible", 3'd1, 32'h6000_0040, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R14 next entry after invalidate", 3'd1, 32'hA000_0040, 1'b0, 1'b0, 1'b0);

        wr_map(3'd0, 1'b0, 1'b1, 3'd7, 1'b0);
        present(32'hA000_0000, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        expect_out("R7 uncached window miss", 3'd2, 32'h0, 1'b0, 1'b1, 1'b0);
        present(32'h8000_0000, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        expect_out("R9 user window with valid entry", 3'd1, 32'h0, 1'b0, 1'b1, 1'b0);
        present(32'hFE3F_FFFF, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R12 RAM high bound", 3'd5, 32'h1E3F_FFFF, 1'b0, 1'b0, 1'b0);
        present(32'hFF80_0040, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R12 past queue", 3'd5, 32'h0, 1'b0, 1'b1, 1'b0);

        // R2 R14: reset mid-run clears outputs and table
        @(negedge clk);
        rst_n = 1'b0;
        in_addr = 32'h8000_0040; in_priv = 1'b1; ext_mode = 1'b1;
        @(negedge clk);
        expect_out("R2 reset mid-run", 3'd0, 32'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R14 reset clears table", 3'd1, 32'h0, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule